// File: doc/BRIEF.md
# Power-Good Timeout Generator

This block drives the power-good (system reset release) output of a multi-rail power sequencer. Each rail brings in a flag that says its output is above its input-referenced threshold. The block also takes a combined undervoltage-good flag, an enable level and a margin request. Power-good goes high only after enable, undervoltage-good and every active rail flag have held true for a programmable timeout. The timeout is a fixed base count plus a programmed extension, both in clock cycles. Power-good drops as soon as any of these conditions fails.

When the enable or undervoltage condition fails before power-good has asserted, the block reports a shutdown abort to the sequencer as a one-cycle pulse. A failure that comes after power-good has asserted is treated as an orderly power-down, and no abort is reported.

While margin is requested, all evaluation is suspended: power-good, the timeout count and the abort output hold still. When margin is released, evaluation carries on from the present flag values. A timeout that has already expired is not restarted.

Top module: `pgt_power_good`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, `power_good` and `seq_abort` are 0. A reset in the middle of a count discards the progress made so far.
- R2: With `margin` low, `power_good` goes to 1 on the T-th consecutive rising edge at which `enable`, `uv_ok` and all active rails are 1, where T = BASE_CYC + `ext_cycles`. It is 0 after any earlier edge.
- R3: A rail whose `rail_mask` bit is 0 is not monitored. Bit i of `rail_mask` governs bit i of `rail_ok`, and a masked rail's flag affects neither the count nor `power_good`.
- R4: With `ext_cycles` = 0, the timeout is exactly BASE_CYC edges.
- R5: If any active rail flag is 0 at an edge while the count is running, the count restarts from zero. A full T further qualifying edges are then needed.
- R6: An edge with `margin` low and `enable`, `uv_ok` or any active rail at 0 leaves `power_good` at 0.
- R7: `seq_abort` is a one-cycle pulse, raised at the first edge (with `margin` low) at which `enable` & `uv_ok` is 0 after having been 1 at the previous monitored edge, and only if `power_good` was 0. A condition failure while `power_good` is 1 gives no pulse.
- R8: At an edge with `margin` = 1, `power_good` and the count keep their values whatever the flags are, and `seq_abort` is 0.
- R9: After `margin` returns to 0, evaluation resumes from the held state. An expired timeout stays expired while the conditions hold, and a partial count continues from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Enable level, 1 = above rising threshold |
| uv_ok | input | 1 | All undervoltage inputs above threshold |
| margin | input | 1 | 1 = margin requested, evaluation frozen |
| rail_ok | input | N_RAIL | Per-rail output-above-threshold flags |
| rail_mask | input | N_RAIL | 1 = rail monitored |
| ext_cycles | input | EXT_W | Programmed timeout extension in cycles |
| power_good | output | 1 | Power-good / reset release |
| seq_abort | output | 1 | One-cycle shutdown-abort pulse to the sequencer |

## Verification
The expiry of the timeout and a failure of the enable condition can land on the same edge. This is provoked by holding every condition true for T-1 edges and then dropping `enable` just before the edge that would complete the count. The expected result is that the failure wins: `power_good` stays 0 and `seq_abort` pulses. A second coincidence is a margin request arriving together with a condition failure mid-count. It is judged by seeing that no abort appears and that the partial count resumes exactly after release.

// File: rtl/pgt_pkg.sv
package pgt_pkg;

  // Total timeout length in cycles: fixed base plus programmed extension.
  function automatic int unsigned timeout_cycles(input int unsigned base,
                                                 input int unsigned ext);
    return base + ext;
  endfunction

  // Counter width able to hold the longest timeout.
  function automatic int unsigned count_width(input int unsigned base,
                                              input int unsigned ext_w);
    return $clog2(base + (1 << ext_w)) + 1;
  endfunction

endpackage

// File: rtl/pgt_rail_qual.sv
module pgt_rail_qual #(
  parameter int unsigned N_RAIL = 3
) (
  input  logic [N_RAIL-1:0] rail_ok,
  input  logic [N_RAIL-1:0] rail_mask,
  output logic              rails_ok
);

  logic [N_RAIL-1:0] rail_pass;

  // A rail passes when it is above threshold or not monitored.
  for (genvar i = 0; i < N_RAIL; i++) begin : g_rail
    assign rail_pass[i] = rail_ok[i] | ~rail_mask[i];
  end

  assign rails_ok = &rail_pass;

endmodule

// File: rtl/pgt_timer.sv
module pgt_timer
  import pgt_pkg::*;
#(
  parameter int unsigned BASE_CYC = 10000,
  parameter int unsigned EXT_W    = 16,
  parameter int unsigned CNT_W    = count_width(BASE_CYC, EXT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             clear,
  input  logic [EXT_W-1:0] ext,
  output logic             done,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] last;
  logic             at_last;

  // The count saturates at T-1; the edge that finds it there completes the timeout.
  assign last    = CNT_W'(timeout_cycles(BASE_CYC, 32'(ext))) - CNT_W'(1);
  assign at_last = (cnt >= last);
  assign done    = advance & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (advance && !at_last) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pgt_ctrl.sv
module pgt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic cond_ok,
  input  logic rails_ok,
  input  logic done,
  output logic pg,
  output logic abort
);

  logic cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      pg     <= 1'b0;
      abort  <= 1'b0;
    end else begin
      abort <= 1'b0;
      if (mon_en) begin
        cond_q <= cond_ok;
        // A power-down request before power-good is a shutdown abort.
        abort  <= cond_q & ~cond_ok & ~pg;
        if (!(cond_ok && rails_ok)) begin
          pg <= 1'b0;
        end else if (done) begin
          pg <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pgt_power_good.sv
module pgt_power_good
  import pgt_pkg::*;
#(
  parameter int unsigned N_RAIL   = 3,
  parameter int unsigned BASE_CYC = 10000,
  parameter int unsigned EXT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              uv_ok,
  input  logic              margin,
  input  logic [N_RAIL-1:0] rail_ok,
  input  logic [N_RAIL-1:0] rail_mask,
  input  logic [EXT_W-1:0]  ext_cycles,
  output logic              power_good,
  output logic              seq_abort
);

  localparam int unsigned CNT_W = count_width(BASE_CYC, EXT_W);

  // Named internal events, visible to the bound checker.
  logic             mon_en;
  logic             cond_ok;
  logic             rails_ok;
  logic             all_ok;
  logic             advance;
  logic             clear;
  logic             done;
  logic [CNT_W-1:0] cnt;

  assign mon_en  = ~margin;
  assign cond_ok = enable & uv_ok;
  assign all_ok  = cond_ok & rails_ok;
  assign advance = mon_en & all_ok;
  assign clear   = mon_en & ~all_ok;

  pgt_rail_qual #(.N_RAIL(N_RAIL)) u_qual (
    .rail_ok   (rail_ok),
    .rail_mask (rail_mask),
    .rails_ok  (rails_ok)
  );

  pgt_timer #(.BASE_CYC(BASE_CYC), .EXT_W(EXT_W), .CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .clear   (clear),
    .ext     (ext_cycles),
    .done    (done),
    .cnt     (cnt)
  );

  pgt_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mon_en   (mon_en),
    .cond_ok  (cond_ok),
    .rails_ok (rails_ok),
    .done     (done),
    .pg       (power_good),
    .abort    (seq_abort)
  );

endmodule

// File: rtl/pgt_power_good_chk.sv
module pgt_power_good_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             margin,
  input logic             cond_ok,
  input logic             rails_ok,
  input logic             done,
  input logic [CNT_W-1:0] cnt,
  input logic             pg,
  input logic             abort
);

  assert_pg_after_timeout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg) |-> $past(done));

  assert_rail_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!margin && !rails_ok) |=> (cnt == '0 && !pg));

  assert_cond_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!margin && !cond_ok) |=> !pg);

  assert_abort_only_before_pg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!pg && $past(!pg)));

  assert_abort_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);

  assert_margin_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    margin |=> ($stable(pg) && $stable(cnt) && !abort));

endmodule

bind pgt_power_good pgt_power_good_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .margin   (margin),
  .cond_ok  (cond_ok),
  .rails_ok (rails_ok),
  .done     (done),
  .cnt      (cnt),
  .pg       (power_good),
  .abort    (seq_abort)
);

// File: tb/pgt_power_good_test.sv
module pgt_power_good_test;

  localparam int unsigned N_RAIL   = 3;
  localparam int unsigned BASE_CYC = 6;
  localparam int unsigned EXT_W    = 3;
  localparam int NV = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, uv_ok = 1'b0, margin = 1'b0;
  logic [N_RAIL-1:0] rail_ok = '0, rail_mask = '0;
  logic [EXT_W-1:0]  ext_cycles = '0;
  logic power_good, seq_abort;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;  // 50 MHz

  pgt_power_good #(.N_RAIL(N_RAIL), .BASE_CYC(BASE_CYC), .EXT_W(EXT_W)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .uv_ok(uv_ok), .margin(margin),
    .rail_ok(rail_ok), .rail_mask(rail_mask), .ext_cycles(ext_cycles),
    .power_good(power_good), .seq_abort(seq_abort)
  );

  // Fields: rep[18:14] en[13] uv[12] margin[11] rails[10:8] mask[7:5] ext[4:2] exp_pg[1] exp_abort[0]
  // Expected values follow T = 6 + ext edges of qualifying input.
  localparam logic [18:0] VEC [NV] = '{
    {5'd5, 1'b1, 1'b1, 1'b0, 3'b111, 3'b111, 3'd0, 1'b0, 1'b0},  // R4 R2 five edges short
    {5'd1, 1'b1, 1'b1, 1'b0, 3'b111, 3'b111, 3'd0, 1'b1, 1'b0},  // R4 R2 sixth edge
    {5'd1, 1'b0, 1'b1, 1'b0, 3'b111, 3'b111, 3'd0, 1'b0, 1'b0},  // R6 R7 drop after pg, no abort
    {5'd3, 1'b1, 1'b1, 1'b0, 3'b111, 3'b111, 3'd0, 1'b0, 1'b0},
    {5'd1, 1'b1, 1'b0, 1'b0, 3'b111, 3'b111, 3'd0, 1'b0, 1'b1},  // R7 abort before pg
    {5'd1, 1'b1, 1'b1, 1'b0, 3'b111, 3'b111, 3'd0, 1'b0, 1'b0},  // R7 single pulse
    {5'd4, 1'b1, 1'b1, 1'b0, 3'b111, 3'b111, 3'd0, 1'b0, 1'b0},
    {5'd1, 1'b1, 1'b1, 1'b0, 3'b101, 3'b111, 3'd0, 1'b0, 1'b0},  // R5 rail drop mid-count
    {5'd5, 1'b1, 1'b1, 1'b0, 3'b111, 3'b111, 3'd0, 1'b0, 1'b0},  // R5 restarted count
    {5'd1, 1'b1, 1'b1, 1'b0, 3'b111, 3'b111, 3'd0, 1'b1, 1'b0},  // R5
    {5'd1, 1'b1, 1'b1, 1'b0, 3'b101, 3'b101, 3'd0, 1'b1, 1'b0},  // R3 masked rail ignored
    {5'd1, 1'b1, 1'b1, 1'b0, 3'b101, 3'b111, 3'd0, 1'b0, 1'b0},  // R6 active rail fails
    {5'd7, 1'b1, 1'b1, 1'b0, 3'b010, 3'b010, 3'd2, 1'b0, 1'b0},  // R2 R3 extended T=8
    {5'd1, 1'b1, 1'b1, 1'b0, 3'b010, 3'b010, 3'd2, 1'b1, 1'b0},  // R2
    {5'd3, 1'b0, 1'b1, 1'b1, 3'b010, 3'b010, 3'd2, 1'b1, 1'b0},  // R8 frozen high
    {5'd1, 1'b1, 1'b1, 1'b0, 3'b010, 3'b010, 3'd2, 1'b1, 1'b0},  // R9 no restart
    {5'd1, 1'b0, 1'b1, 1'b0, 3'b010, 3'b010, 3'd2, 1'b0, 1'b0},
    {5'd3, 1'b1, 1'b1, 1'b0, 3'b010, 3'b010, 3'd2, 1'b0, 1'b0},
    {5'd4, 1'b1, 1'b1, 1'b1, 3'b000, 3'b010, 3'd2, 1'b0, 1'b0},  // R8 rail loss ignored
    {5'd1, 1'b0, 1'b1, 1'b1, 3'b000, 3'b010, 3'd2, 1'b0, 1'b0},  // R8 no abort in margin
    {5'd4, 1'b1, 1'b1, 1'b0, 3'b010, 3'b010, 3'd2, 1'b0, 1'b0},  // R9 partial resumes
    {5'd1, 1'b1, 1'b1, 1'b0, 3'b010, 3'b010, 3'd2, 1'b1, 1'b0},  // R9 3+5 edges
    {5'd1, 1'b0, 1'b1, 1'b0, 3'b010, 3'b010, 3'd2, 1'b0, 1'b0},
    {5'd7, 1'b1, 1'b1, 1'b0, 3'b010, 3'b010, 3'd2, 1'b0, 1'b0},
    {5'd1, 1'b0, 1'b1, 1'b0, 3'b010, 3'b010, 3'd2, 1'b0, 1'b1}   // R7 R6 failure on expiry edge
  };

  localparam string TAG [NV] = '{
    "R4", "R2", "R6", "R2", "R7", "R7", "R2", "R5", "R5", "R5", "R3", "R6", "R2",
    "R2", "R8", "R9", "R6", "R2", "R8", "R8", "R9", "R9", "R6", "R2", "R7"
  };

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) step();
    check("R1", "power_good in reset", power_good, 1'b0);
    check("R1", "seq_abort in reset", seq_abort, 1'b0);
    rst_n = 1'b1;
    step();
    check("R1", "power_good after reset", power_good, 1'b0);

    for (int v = 0; v < NV; v++) begin
      enable     = VEC[v][13];
      uv_ok      = VEC[v][12];
      margin     = VEC[v][11];
      rail_ok    = VEC[v][10:8];
      rail_mask  = VEC[v][7:5];
      ext_cycles = VEC[v][4:2];
      for (int r = 0; r < int'(VEC[v][18:14]); r++) step();
      check(TAG[v], $sformatf("vector %0d power_good", v), power_good, VEC[v][1]);
      check(TAG[v], $sformatf("vector %0d seq_abort", v), seq_abort, VEC[v][0]);
    end

    // R1: reset in the middle of a count discards progress
    enable = 1'b1; uv_ok = 1'b1; margin = 1'b0;
    rail_ok = 3'b111; rail_mask = 3'b111; ext_cycles = '0;
    repeat (3) step();
    rst_n = 1'b0;
    step();
    check("R1", "power_good during mid-count reset", power_good, 1'b0);
    check("R1", "seq_abort during mid-count reset", seq_abort, 1'b0);
    rst_n = 1'b1;
    repeat (5) step();
    check("R1", "power_good 5 edges after reset", power_good, 1'b0);
    step();
    check("R1", "power_good 6 edges after reset", power_good, 1'b1);

    // R4: largest extension still counts the exact total
    enable = 1'b0;
    step();
    enable = 1'b1; ext_cycles = 3'd7;
    repeat (12) step();
    check("R4", "power_good at T-1 with ext 7", power_good, 1'b0);
    step();
    check("R4", "power_good at T with ext 7", power_good, 1'b1);

    finish_run();
  end

endmodule